// File: doc/BRIEF.md
# Flash in-system update sequencer

This block steps an on-chip configuration flash through a complete image update. A single start strobe launches the sequence. The sequencer first compares the identity word read from the device against an expected value. It then moves the user I/O into programming mode, erases the sector, and writes every word of the sector. The word contents come from an external word source that is indexed by address. Next it reads back every word and compares each one with the source. Finally it returns the I/O to user mode. The flash is driven through a small command interface: an address bus, a write-data bus, three separate command pulses (erase, program, read), a ready flag and a read-data return.

Two update styles are selected at start. In the normal style the user I/O is tri-stated while the update runs, and a one-cycle reset request is raised after a clean finish so that the device restarts into the new image. In the live style the user I/O stays active for the whole sequence and no reset is requested. The new image then only takes effect after the next reconfiguration. Failures are reported through an error code: an identity mismatch aborts before anything is touched, and a read-back mismatch also reports the failing address. Busy, done and the error code are held so that the surrounding logic can poll them.

Top module: `flash_update_seq`

## Requirements
- R1: In the first busy cycle after start, `dev_id_i` is compared with `exp_id_i`. On a mismatch, `err_o` becomes 1, `done_o` rises, and no command pulse or I/O tri-state is produced.
- R2: After a good identity check, the commands follow a fixed order. First comes one erase with `fl_addr_o` equal to SECT_BASE. Then one program command goes to each address from SECT_BASE up to SECT_BASE+SECT_WORDS-1 in ascending order. Then one read command goes to each of the same addresses, again ascending.
- R3: Each command pulse stays high for exactly PULSE_CYC cycles. At most one of the erase, program and read pulses is high at any time. `fl_addr_o` and `fl_wdata_o` stay constant while a program pulse is high.
- R4: A command pulse starts only when `fl_ready_i` was high in the cycle in which the sequencer issued the command.
- R5: The data written by each program command is `src_data_i` for that word's address, presented on `src_addr_o`. During read-back, `fl_rdata_i` is compared with `src_data_i` for the same address.
- R6: On a read-back mismatch, `err_o` becomes 2 and `fail_addr_o` holds the failing address. No further read is issued. The exit transition still runs, so `io_tristate_o` is low again when `done_o` rises.
- R7: In normal style, `io_tristate_o` is high during every command pulse and only while `busy_o` is high. On a clean finish, `reset_req_o` pulses for one cycle, together with the rise of `done_o` and with `err_o` equal to 0.
- R8: In live style (`live_i` high at start), `io_tristate_o` stays low for the whole run and `reset_req_o` is never raised.
- R9: A start request is ignored while `busy_o` is high. `done_o` and `err_o` keep their values until the next accepted start, and that start clears both.
- R10: While reset is applied and after it, before any start, `busy_o`, `done_o`, `err_o`, `io_tristate_o`, `reset_req_o` and all three pulses are low.
- R11: In normal style, at least SETTLE_CYC cycles pass between the rise of `io_tristate_o` and the first command pulse. At least SETTLE_CYC cycles also pass between the fall of the last pulse and the fall of `io_tristate_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe, taken only when idle |
| live_i | input | 1 | 1 = live update style, 0 = normal style; sampled at start |
| exp_id_i | input | IDW | Expected device identity |
| dev_id_i | input | IDW | Identity read from the device |
| src_addr_o | output | AW | Address of the source word currently needed |
| src_data_i | input | DW | Source word for `src_addr_o` (combinational return) |
| fl_addr_o | output | AW | Flash command address |
| fl_wdata_o | output | DW | Flash program data |
| fl_erase_o | output | 1 | Erase pulse |
| fl_prog_o | output | 1 | Program pulse |
| fl_read_o | output | 1 | Read pulse |
| fl_ready_i | input | 1 | Flash ready for the next command; read data valid when high |
| fl_rdata_i | input | DW | Flash read data |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished, held until the next start |
| err_o | output | 2 | 0 = none, 1 = identity mismatch, 2 = read-back mismatch |
| fail_addr_o | output | AW | Address of the first read-back mismatch |
| io_tristate_o | output | 1 | User I/O tri-state enable |
| reset_req_o | output | 1 | One-cycle reset request after a clean normal-style update |

## Verification
On every cycle the assertions check the following. No two command pulses overlap. The program address and data hold still under a pulse. Tri-state is only high inside a busy run and covers every pulse in normal style. Live style never tri-states and never requests reset. A pulse only starts after ready was seen. An identity error never comes with flash activity. The reset request only appears together with a clean done. Some behaviour can only be shown by the bench scenarios. These are the exact order and contents of the erase, program and read commands, the pulse length, the settle gaps around the I/O transition, the stop after a corrupted word with its reported address, and the fact that a start issued in mid-run changes nothing.

// File: rtl/fus_pkg.sv
package fus_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_IDCHK,
    S_ENTER,
    S_ERASE_ISSUE,
    S_ERASE_WAIT,
    S_PROG_ISSUE,
    S_PROG_WAIT,
    S_VER_ISSUE,
    S_VER_WAIT,
    S_VER_CMP,
    S_EXIT,
    S_FINISH
  } fus_state_e;

  typedef enum logic [1:0] {
    ERR_NONE   = 2'd0,
    ERR_ID     = 2'd1,
    ERR_VERIFY = 2'd2
  } fus_err_e;

  // one-hot command kinds for the pulse timer
  localparam int unsigned NKIND = 3;
  localparam logic [NKIND-1:0] K_ERASE = 3'b001;
  localparam logic [NKIND-1:0] K_PROG  = 3'b010;
  localparam logic [NKIND-1:0] K_READ  = 3'b100;

endpackage

// File: rtl/fus_hold_timer.sv
module fus_hold_timer #(
  parameter int unsigned NK  = 1,
  parameter int unsigned CYC = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [NK-1:0] kind_i,
  output logic [NK-1:0] hold_o,
  output logic          fin_o
);

  localparam int unsigned CW = (CYC < 2) ? 1 : $clog2(CYC + 1);

  logic [CW-1:0] cnt_q;
  logic [NK-1:0] hold_q;
  logic          fin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      hold_q <= '0;
      fin_q  <= 1'b0;
    end else begin
      fin_q <= 1'b0;
      if (start_i) begin
        hold_q <= kind_i;
        cnt_q  <= CW'(CYC - 1);
      end else if (hold_q != '0) begin
        if (cnt_q == '0) begin
          hold_q <= '0;
          fin_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign hold_o = hold_q;
  assign fin_o  = fin_q;

endmodule

// File: rtl/fus_addr_ctr.sv
module fus_addr_ctr #(
  parameter int unsigned AW    = 8,
  parameter int unsigned BASE  = 0,
  parameter int unsigned WORDS = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_i,
  input  logic          inc_i,
  output logic [AW-1:0] addr_o,
  output logic          last_o
);

  localparam int unsigned IW = (WORDS < 2) ? 1 : $clog2(WORDS);

  logic [IW-1:0] idx_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q  <= '0;
      addr_q <= AW'(BASE);
    end else if (load_i) begin
      idx_q  <= '0;
      addr_q <= AW'(BASE);
    end else if (inc_i) begin
      idx_q  <= idx_q + 1'b1;
      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
  assign last_o = (idx_q == IW'(WORDS - 1));

endmodule

// File: rtl/flash_update_seq.sv
module flash_update_seq
  import fus_pkg::*;
#(
  parameter int unsigned AW         = 8,
  parameter int unsigned DW         = 16,
  parameter int unsigned IDW        = 32,
  parameter int unsigned SECT_BASE  = 32,
  parameter int unsigned SECT_WORDS = 16,
  parameter int unsigned PULSE_CYC  = 4,
  parameter int unsigned SETTLE_CYC = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start_i,
  input  logic           live_i,
  input  logic [IDW-1:0] exp_id_i,
  input  logic [IDW-1:0] dev_id_i,
  output logic [AW-1:0]  src_addr_o,
  input  logic [DW-1:0]  src_data_i,
  output logic [AW-1:0]  fl_addr_o,
  output logic [DW-1:0]  fl_wdata_o,
  output logic           fl_erase_o,
  output logic           fl_prog_o,
  output logic           fl_read_o,
  input  logic           fl_ready_i,
  input  logic [DW-1:0]  fl_rdata_i,
  output logic           busy_o,
  output logic           done_o,
  output logic [1:0]     err_o,
  output logic [AW-1:0]  fail_addr_o,
  output logic           io_tristate_o,
  output logic           reset_req_o
);

  fus_state_e       state_q;
  fus_err_e         err_q;
  logic             busy_q, done_q, live_q, tri_q, rreq_q;
  logic [AW-1:0]    fl_addr_q, fail_addr_q;
  logic [DW-1:0]    fl_wdata_q;
  logic             pulse_go_q, settle_go_q;
  logic [NKIND-1:0] pulse_kind_q;

  logic [NKIND-1:0] pulse_hold;
  logic             pulse_fin;
  logic [0:0]       settle_hold;
  logic             settle_fin;
  logic [AW-1:0]    ctr_addr;
  logic             ctr_last, ctr_load, ctr_inc, word_match;

  // command pulse generator: one-hot kind held for PULSE_CYC cycles
  fus_hold_timer #(.NK(NKIND), .CYC(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .start_i (pulse_go_q),
    .kind_i  (pulse_kind_q),
    .hold_o  (pulse_hold),
    .fin_o   (pulse_fin)
  );

  // I/O transition settle timer for the enter and exit phases
  fus_hold_timer #(.NK(1), .CYC(SETTLE_CYC)) u_settle (
    .clk     (clk),
    .rst     (rst),
    .start_i (settle_go_q),
    .kind_i  (1'b1),
    .hold_o  (settle_hold),
    .fin_o   (settle_fin)
  );

  fus_addr_ctr #(.AW(AW), .BASE(SECT_BASE), .WORDS(SECT_WORDS)) u_ctr (
    .clk    (clk),
    .rst    (rst),
    .load_i (ctr_load),
    .inc_i  (ctr_inc),
    .addr_o (ctr_addr),
    .last_o (ctr_last)
  );

  assign word_match = (fl_rdata_i == src_data_i);

  // the counter restarts at the sector base before each pass
  always_comb begin
    ctr_load = 1'b0;
    ctr_inc  = 1'b0;
    unique case (state_q)
      S_ERASE_WAIT: ctr_load = pulse_fin;
      S_PROG_WAIT: begin
        ctr_load = pulse_fin && ctr_last;
        ctr_inc  = pulse_fin && !ctr_last;
      end
      S_VER_CMP: ctr_inc = fl_ready_i && word_match && !ctr_last;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= S_IDLE;
      err_q        <= ERR_NONE;
      busy_q       <= 1'b0;
      done_q       <= 1'b0;
      live_q       <= 1'b0;
      tri_q        <= 1'b0;
      rreq_q       <= 1'b0;
      fl_addr_q    <= '0;
      fl_wdata_q   <= '0;
      fail_addr_q  <= '0;
      pulse_go_q   <= 1'b0;
      pulse_kind_q <= '0;
      settle_go_q  <= 1'b0;
    end else begin
      pulse_go_q  <= 1'b0;
      settle_go_q <= 1'b0;
      rreq_q      <= 1'b0;
      unique case (state_q)
        S_IDLE: if (start_i) begin
          busy_q      <= 1'b1;
          done_q      <= 1'b0;
          err_q       <= ERR_NONE;
          fail_addr_q <= '0;
          live_q      <= live_i;
          state_q     <= S_IDCHK;
        end
        S_IDCHK: if (dev_id_i != exp_id_i) begin
          err_q   <= ERR_ID;
          state_q <= S_FINISH;
        end else begin
          tri_q       <= !live_q;
          settle_go_q <= 1'b1;
          state_q     <= S_ENTER;
        end
        S_ENTER: if (settle_fin) state_q <= S_ERASE_ISSUE;
        S_ERASE_ISSUE: if (fl_ready_i) begin
          fl_addr_q    <= AW'(SECT_BASE);
          pulse_go_q   <= 1'b1;
          pulse_kind_q <= K_ERASE;
          state_q      <= S_ERASE_WAIT;
        end
        S_ERASE_WAIT: if (pulse_fin) state_q <= S_PROG_ISSUE;
        S_PROG_ISSUE: if (fl_ready_i) begin
          fl_addr_q    <= ctr_addr;
          fl_wdata_q   <= src_data_i;
          pulse_go_q   <= 1'b1;
          pulse_kind_q <= K_PROG;
          state_q      <= S_PROG_WAIT;
        end
        S_PROG_WAIT: if (pulse_fin) state_q <= ctr_last ? S_VER_ISSUE : S_PROG_ISSUE;
        S_VER_ISSUE: if (fl_ready_i) begin
          fl_addr_q    <= ctr_addr;
          pulse_go_q   <= 1'b1;
          pulse_kind_q <= K_READ;
          state_q      <= S_VER_WAIT;
        end
        S_VER_WAIT: if (pulse_fin) state_q <= S_VER_CMP;
        S_VER_CMP: if (fl_ready_i) begin
          if (!word_match) begin
            err_q       <= ERR_VERIFY;
            fail_addr_q <= ctr_addr;
            settle_go_q <= 1'b1;
            state_q     <= S_EXIT;
          end else if (ctr_last) begin
            settle_go_q <= 1'b1;
            state_q     <= S_EXIT;
          end else begin
            state_q <= S_VER_ISSUE;
          end
        end
        S_EXIT: if (settle_fin) begin
          tri_q   <= 1'b0;
          state_q <= S_FINISH;
        end
        S_FINISH: begin
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
          rreq_q  <= (err_q == ERR_NONE) && !live_q;
          state_q <= S_IDLE;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign src_addr_o    = ctr_addr;
  assign fl_addr_o     = fl_addr_q;
  assign fl_wdata_o    = fl_wdata_q;
  assign fl_erase_o    = pulse_hold[0];
  assign fl_prog_o     = pulse_hold[1];
  assign fl_read_o     = pulse_hold[2];
  assign busy_o        = busy_q;
  assign done_o        = done_q;
  assign err_o         = err_q;
  assign fail_addr_o   = fail_addr_q;
  assign io_tristate_o = tri_q;
  assign reset_req_o   = rreq_q;

endmodule

// File: rtl/fus_checker.sv
module fus_checker #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 16
) (
  input logic          clk,
  input logic          rst,
  input logic          fl_erase_o,
  input logic          fl_prog_o,
  input logic          fl_read_o,
  input logic [AW-1:0] fl_addr_o,
  input logic [DW-1:0] fl_wdata_o,
  input logic          fl_ready_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [1:0]    err_o,
  input logic          io_tristate_o,
  input logic          reset_req_o,
  input logic          live_q
);

  logic any_pulse;
  assign any_pulse = fl_erase_o | fl_prog_o | fl_read_o;

  assert_pulse_onehot_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fl_erase_o, fl_prog_o, fl_read_o}));

  assert_prog_bus_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (fl_prog_o && $past(fl_prog_o)) |-> ($stable(fl_addr_o) && $stable(fl_wdata_o)));

  // issue edge samples ready, the timer starts one edge later
  assert_pulse_after_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(any_pulse) |-> $past(fl_ready_i, 2));

  assert_id_err_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    (err_o == 2'd1) |-> (!any_pulse && !io_tristate_o));

  assert_tri_inside_busy_R7: assert property (@(posedge clk) disable iff (rst)
    io_tristate_o |-> busy_o);

  assert_tri_covers_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (any_pulse && !live_q) |-> io_tristate_o);

  assert_reset_req_clean_R7: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> (done_o && err_o == 2'd0 && !io_tristate_o));

  assert_live_no_tri_R8: assert property (@(posedge clk) disable iff (rst)
    live_q |-> !io_tristate_o);

  assert_live_no_reset_R8: assert property (@(posedge clk) disable iff (rst)
    reset_req_o |-> !live_q);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

endmodule

bind flash_update_seq fus_checker #(.AW(AW), .DW(DW)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .fl_erase_o    (fl_erase_o),
  .fl_prog_o     (fl_prog_o),
  .fl_read_o     (fl_read_o),
  .fl_addr_o     (fl_addr_o),
  .fl_wdata_o    (fl_wdata_o),
  .fl_ready_i    (fl_ready_i),
  .busy_o        (busy_o),
  .done_o        (done_o),
  .err_o         (err_o),
  .io_tristate_o (io_tristate_o),
  .reset_req_o   (reset_req_o),
  .live_q        (live_q)
);

// File: tb/flash_update_seq_tb.sv
module flash_update_seq_tb;

  localparam int AW = 8, DW = 16, IDW = 32;
  localparam int BASE = 32, WORDS = 16, PCYC = 4, SCYC = 3;
  localparam logic [IDW-1:0] GOOD_ID = 32'h0C0F_FEE5;

  logic clk = 1'b0, rst = 1'b1;
  logic start_i = 1'b0, live_i = 1'b0;
  logic [IDW-1:0] exp_id_i = GOOD_ID, dev_id_i = GOOD_ID;
  logic [AW-1:0] src_addr_o, fl_addr_o, fail_addr_o;
  logic [DW-1:0] src_data_i, fl_wdata_o, fl_rdata_i;
  logic fl_erase_o, fl_prog_o, fl_read_o, fl_ready_i = 1'b1;
  logic busy_o, done_o, io_tristate_o, reset_req_o;
  logic [1:0] err_o;

  always #2 clk = ~clk;

  flash_update_seq #(
    .AW(AW), .DW(DW), .IDW(IDW), .SECT_BASE(BASE), .SECT_WORDS(WORDS),
    .PULSE_CYC(PCYC), .SETTLE_CYC(SCYC)
  ) u_dut (.*);

  function automatic logic [DW-1:0] srcf(input logic [AW-1:0] a);
    return DW'({8'h00, a} * 16'h1357) ^ 16'h5A3C;
  endfunction

  assign src_data_i = srcf(src_addr_o);

  // behavioural flash model
  logic [DW-1:0] mem [WORDS];
  logic [3:0] ridx;
  assign ridx = 4'(fl_addr_o - AW'(BASE));
  assign fl_rdata_i = mem[ridx];

  int checks = 0, errors = 0, cyc = 0;
  int exp_kind[$], exp_addr[$], exp_data[$];
  bit run_active = 0, run_live = 0, first_pulse = 0;
  int corrupt_addr = -1;
  int rreq_cnt = 0, tri_seen = 0, pulse_cnt = 0, pwidth = 0, bcnt = 0;
  int tri_rise_cyc = 0, last_fall_cyc = 0;
  logic [2:0] prev_p = '0;
  logic prev_tri = 1'b0, rdy_old = 1'b1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", req, what, act, expv, cyc);
    end
  endtask

  // reference model, compared every clock at the falling edge
  always @(negedge clk) begin
    logic [2:0] p;
    p = {fl_read_o, fl_prog_o, fl_erase_o};
    cyc++;
    if (!rst) begin
      if (run_active && run_live) chk(!io_tristate_o, "R8", "tristate in live run", io_tristate_o, 0);
      if (run_active && !run_live && p != 0)
        chk(io_tristate_o, "R7", "tristate during pulse", io_tristate_o, 1);
      chk($countones(p) <= 1, "R3", "pulse overlap", p, 0);
      if (reset_req_o) rreq_cnt++;
      if (io_tristate_o && !prev_tri) begin tri_seen++; tri_rise_cyc = cyc; end
      if (!io_tristate_o && prev_tri)
        chk(cyc - last_fall_cyc >= SCYC, "R11", "exit settle gap", cyc - last_fall_cyc, SCYC);
      if (p != 0 && prev_p == 0) begin
        pulse_cnt++;
        chk(rdy_old, "R4", "pulse without ready", rdy_old, 1);
        if (first_pulse && !run_live)
          chk(cyc - tri_rise_cyc >= SCYC, "R11", "enter settle gap", cyc - tri_rise_cyc, SCYC);
        first_pulse = 0;
        if (exp_kind.size() == 0) chk(0, "R2", "unexpected command", p, 0);
        else begin
          int k, a, d;
          k = exp_kind.pop_front(); a = exp_addr.pop_front(); d = exp_data.pop_front();
          chk(p == 3'(k), "R2", "command kind", p, k);
          chk(fl_addr_o == AW'(a), "R2", "command address", fl_addr_o, a);
          if (k == 2) chk(fl_wdata_o == DW'(d), "R5", "program data", fl_wdata_o, d);
        end
        if (p[0]) for (int i = 0; i < WORDS; i++) mem[i] = '1;
        if (p[1]) mem[ridx] = (int'(fl_addr_o) == corrupt_addr) ? (fl_wdata_o ^ 16'h0001) : fl_wdata_o;
      end
      if (p != 0) pwidth++;
      if (p == 0 && prev_p != 0) begin
        chk(pwidth == PCYC, "R3", "pulse length", pwidth, PCYC);
        pwidth = 0;
        last_fall_cyc = cyc;
      end
    end
    prev_p = p;
    prev_tri = io_tristate_o;
    rdy_old = fl_ready_i;
    if (p != 0) begin fl_ready_i = 1'b0; bcnt = 1 + (pulse_cnt % 3); end
    else if (bcnt > 0) begin fl_ready_i = 1'b0; bcnt--; end
    else fl_ready_i = 1'b1;
  end

  task automatic run_case(input string name, input bit live, input bit id_ok, input int bad);
    int wait_n;
    corrupt_addr = bad;
    exp_kind.delete(); exp_addr.delete(); exp_data.delete();
    if (id_ok) begin
      exp_kind.push_back(1); exp_addr.push_back(BASE); exp_data.push_back(0);
      for (int i = 0; i < WORDS; i++) begin
        exp_kind.push_back(2); exp_addr.push_back(BASE + i); exp_data.push_back(int'(srcf(AW'(BASE + i))));
      end
      for (int i = 0; i < WORDS; i++) begin
        exp_kind.push_back(4); exp_addr.push_back(BASE + i); exp_data.push_back(0);
        if (BASE + i == bad) break;
      end
    end
    rreq_cnt = 0; tri_seen = 0;
    @(negedge clk);
    start_i = 1'b1; live_i = live; dev_id_i = id_ok ? GOOD_ID : (GOOD_ID ^ 32'h0000_0100);
    run_live = live; run_active = 1; first_pulse = 1;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o && !done_o && err_o == 0, "R9", {name, " start clears done/err"}, {busy_o, done_o, err_o}, 4'b1000);
    if (id_ok) begin
      repeat (12) @(negedge clk);
      start_i = 1'b1; live_i = !live; dev_id_i = GOOD_ID ^ 32'h1;
      @(negedge clk);
      start_i = 1'b0;
    end
    wait_n = 0;
    while (!done_o && wait_n < 20000) begin @(negedge clk); wait_n++; end
    chk(done_o, "R9", {name, " run completes"}, done_o, 1);
    @(negedge clk);
    run_active = 0;
    chk(!busy_o, "R9", {name, " busy low at end"}, busy_o, 0);
    chk(exp_kind.size() == 0, "R2", {name, " all commands issued"}, exp_kind.size(), 0);
    chk(!io_tristate_o, "R6", {name, " io released at end"}, io_tristate_o, 0);
    if (!id_ok) begin
      chk(err_o == 2'd1, "R1", {name, " id error code"}, err_o, 1);
      chk(tri_seen == 0, "R1", {name, " no io change"}, tri_seen, 0);
    end else if (bad >= 0) begin
      chk(err_o == 2'd2, "R6", {name, " verify error code"}, err_o, 2);
      chk(fail_addr_o == AW'(bad), "R6", {name, " failing address"}, fail_addr_o, bad);
    end else begin
      chk(err_o == 2'd0, "R5", {name, " clean read-back"}, err_o, 0);
    end
    if (live) chk(tri_seen == 0, "R8", {name, " live keeps io"}, tri_seen, 0);
    else if (id_ok) chk(tri_seen == 1, "R7", {name, " io tri-stated once"}, tri_seen, 1);
    chk(rreq_cnt == ((!live && id_ok && bad < 0) ? 1 : 0), live ? "R8" : "R7",
        {name, " reset request count"}, rreq_cnt, (!live && id_ok && bad < 0) ? 1 : 0);
    repeat (10) @(negedge clk);
    chk(done_o && !busy_o, "R9", {name, " done held"}, done_o, 1);
  endtask

  initial begin
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, io_tristate_o, reset_req_o, fl_erase_o, fl_prog_o, fl_read_o} == 0,
        "R10", "outputs in reset", {busy_o, done_o, err_o, io_tristate_o, reset_req_o}, 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy_o, done_o, err_o, io_tristate_o, reset_req_o} == 0, "R10", "outputs after reset",
        {busy_o, done_o, err_o, io_tristate_o, reset_req_o}, 0);
    run_case("normal", 1'b0, 1'b1, -1);
    run_case("live", 1'b1, 1'b1, -1);
    run_case("badid", 1'b0, 1'b0, -1);
    run_case("corrupt", 1'b0, 1'b1, BASE + 5);
    run_case("live_corrupt", 1'b1, 1'b1, BASE + WORDS - 1);
    run_case("normal_again", 1'b0, 1'b1, -1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule